// File: doc/BRIEF.md
# Exposure and Frame-Mode Sequencer

This block sets the exposure time and paces the frames of an image-sensor readout pipeline. A byte-wide write port loads a small set of staging registers: a mode byte, a horizontal-sync width and three exposure bytes. At each frame boundary the sequencer copies the staged values into its working set. It then runs a short start phase, an exposure phase and a readout phase. The readout phase emits a line-valid window for each line.

Exposure is counted in one of two units. In the first, each count is one pixel clock. In the second, each count is one whole line, and a line is a fixed base number of pixel clocks plus the programmed sync width. The sequencer either repeats frames back to back or, in single-shot mode, reads one frame and then parks in a halted state. It re-arms from there on a mode write or on an enable cycle.

A hardware enable input and an active-low software-enable bit gate all activity. When the sequencer is not enabled it sits idle and drives no strobes.

Top module: `expo_seq`

## Requirements
- R1: While reset is asserted, all four outputs are low. When reset is released with `hw_en` high and the software-off bit clear, `frame_start` pulses on the first cycle after the first clock edge.
- R2: With mode bit 0 = 1 (pixel unit), `int_done` follows `frame_start` by exactly N+1 cycles. N is the 24-bit value {addr 2, addr 3, addr 4}, with address 2 as the most significant byte.
- R3: With mode bit 0 = 0 (line unit), `int_done` follows `frame_start` by exactly M·L+1 cycles. M is the 16-bit value {addr 2, addr 3} and L is the line length. The byte at address 4 has no effect in this mode.
- R4: The line length L is BASE_PPL (default 414) plus the byte at address 1. It applies both to line-unit exposure and to readout lines.
- R5: After reset, the mode register is 0, which selects line-unit exposure and continuous operation.
- R6: An exposure target of zero gives `int_done` on the cycle directly after `frame_start`.
- R7: With mode bit 1 = 0 (continuous), successive `frame_start` pulses are spaced by the exposure spacing of R2 or R3, plus 1, plus ROWS·L cycles.
- R8: Each frame produces exactly ROWS·ACT_PIX cycles of `line_valid`. `line_valid` is never high together with `frame_start` or `int_done`.
- R9: With mode bit 1 = 1 (single shot), one `frame_start` is produced. After that frame's readout, `halted` rises and stays high, and no further frame starts.
- R10: While halted, a write to address 0, or `hw_en` going low and back high, clears `halted` and runs exactly one more frame.
- R11: One cycle after `hw_en` is sampled low, all outputs are low, including `halted`. They stay low, with no frame started, for as long as `hw_en` stays low.
- R12: Mode bit 2 = 1 (software off) idles the sequencer like R11. Clearing the bit with `hw_en` high gives a `frame_start` within two cycles of the write.
- R13: A write made during a frame leaves that frame's exposure unchanged and takes effect from the next `frame_start`.
- R14: `frame_start` and `int_done` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable; low forces power-down idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 mode, 1 sync width, 2/3/4 exposure high/mid/low |
| wr_data | input | 8 | Register write data |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| line_valid | output | 1 | High during the active pixels of each readout line |
| int_done | output | 1 | One-cycle pulse when exposure ends |
| halted | output | 1 | Sticky flag after a single-shot frame |

## Verification
A wrong unit select, a stale line length or a miscounted exposure shows up in the first frame: the gap from `frame_start` to `int_done` is off by a multiple of the line length or by single cycles. The bench measures that gap to the exact cycle. A readout counter that wraps at the wrong point changes both the frame-to-frame period and the count of `line_valid` cycles, so it is caught by the second `frame_start`. A sequencer state that fails to park, fails to re-arm or ignores an enable shows as an extra or a missing `frame_start` within one frame period.

// File: rtl/expo_seq_pkg.sv
package expo_seq_pkg;

   localparam int HSW_W = 8;
   localparam int EXP_W = 24;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_MODE    = 3'd0;
   localparam logic [ADDR_W-1:0] A_HSW     = 3'd1;
   localparam logic [ADDR_W-1:0] A_EXP_HI  = 3'd2;
   localparam logic [ADDR_W-1:0] A_EXP_MID = 3'd3;
   localparam logic [ADDR_W-1:0] A_EXP_LO  = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_EXPOSE,
      ST_READ,
      ST_HALT
   } seq_state_t;

   typedef struct packed {
      logic             pix_unit;
      logic             one_shot;
      logic [HSW_W-1:0] hsw;
      logic [EXP_W-1:0] expo;
   } expo_cfg_t;

endpackage

// File: rtl/expo_seq_regs.sv
module expo_seq_regs
   import expo_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output expo_cfg_t         staged,
   output logic              sw_off,
   output logic              mode_wr
);

   localparam int NBYTES = EXP_W / 8;

   logic [NBYTES-1:0][7:0] expo_q;
   logic [HSW_W-1:0]       hsw_q;
   logic                   pix_q;
   logic                   shot_q;

   assign mode_wr = wr_en && (wr_addr == A_MODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         expo_q <= '0;
         hsw_q  <= '0;
         pix_q  <= 1'b0;
         shot_q <= 1'b0;
         sw_off <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_MODE) begin
            pix_q  <= wr_data[0];
            shot_q <= wr_data[1];
            sw_off <= wr_data[2];
         end
         if (wr_addr == A_HSW)
            hsw_q <= wr_data[HSW_W-1:0];
         // byte 0 is least significant; it sits at the highest address
         for (int b = 0; b < NBYTES; b++) begin
            if (wr_addr == A_EXP_LO - ADDR_W'(b))
               expo_q[b] <= wr_data;
         end
      end
   end

   always_comb begin
      staged.pix_unit = pix_q;
      staged.one_shot = shot_q;
      staged.hsw      = hsw_q;
      staged.expo     = expo_q;
   end

endmodule

// File: rtl/expo_seq_intcnt.sv
module expo_seq_intcnt
   import expo_seq_pkg::*;
#(
   parameter int PPL_W = 10
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             pix_unit,
   input  logic [EXP_W-1:0] target,
   input  logic [PPL_W-1:0] ppl,
   output logic             hit
);

   logic [EXP_W-1:0] cnt;
   logic [PPL_W-1:0] pcnt;
   logic             line_wrap;

   assign line_wrap = (pcnt == ppl - PPL_W'(1));

   always_comb begin
      if (pix_unit)
         hit = (cnt == target);
      else
         hit = (cnt[15:0] == target[EXP_W-1:8]) && (pcnt == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt  <= '0;
         pcnt <= '0;
      end else if (en && !hit) begin
         if (pix_unit) begin
            cnt <= cnt + EXP_W'(1);
         end else if (line_wrap) begin
            pcnt <= '0;
            cnt  <= cnt + EXP_W'(1);
         end else begin
            pcnt <= pcnt + PPL_W'(1);
         end
      end
   end

endmodule

// File: rtl/expo_seq_fsm.sv
module expo_seq_fsm
   import expo_seq_pkg::*;
#(
   parameter int PPL_W   = 10,
   parameter int ACT_PIX = 400,
   parameter int ROWS    = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             mode_wr,
   input  logic             one_shot,
   input  logic             exp_hit,
   input  logic [PPL_W-1:0] ppl,
   output seq_state_t       state,
   output logic             line_valid
);

   localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

   logic [PPL_W-1:0] pix;
   logic [ROW_W-1:0] row;
   logic             eol;
   logic             eof;
   seq_state_t       nxt;

   assign eol        = (pix == ppl - PPL_W'(1));
   assign eof        = eol && (row == ROW_W'(ROWS - 1));
   assign line_valid = (state == ST_READ) && (pix < PPL_W'(ACT_PIX));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:   nxt = ST_START;
         ST_START:  nxt = ST_EXPOSE;
         ST_EXPOSE: if (exp_hit) nxt = ST_READ;
         ST_READ:   if (eof) nxt = one_shot ? ST_HALT : ST_START;
         ST_HALT:   if (mode_wr) nxt = ST_START;
         default:   nxt = ST_IDLE;
      endcase
      if (!run)
         nxt = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || state != ST_READ) begin
         pix <= '0;
         row <= '0;
      end else if (eol) begin
         pix <= '0;
         row <= row + ROW_W'(1);
      end else begin
         pix <= pix + PPL_W'(1);
      end
   end

endmodule

// File: rtl/expo_seq.sv
module expo_seq
   import expo_seq_pkg::*;
#(
   parameter int BASE_PPL = 414,
   parameter int ACT_PIX  = 400,
   parameter int ROWS     = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              frame_start,
   output logic              line_valid,
   output logic              int_done,
   output logic              halted
);

   localparam int PPL_MAX = BASE_PPL + (1 << HSW_W) - 1;
   localparam int PPL_W   = $clog2(PPL_MAX + 1);

   if (ACT_PIX < 1 || ACT_PIX > BASE_PPL) begin : g_bad_act
      $error("expo_seq: ACT_PIX must lie in 1..BASE_PPL");
   end
   if (ROWS < 1) begin : g_bad_rows
      $error("expo_seq: ROWS must be at least 1");
   end
   if (BASE_PPL < 2) begin : g_bad_ppl
      $error("expo_seq: BASE_PPL must be at least 2");
   end

   expo_cfg_t        staged;
   expo_cfg_t        act;
   logic             sw_off;
   logic             mode_wr;
   logic             run;
   logic             exp_hit;
   logic [PPL_W-1:0] ppl;
   seq_state_t       state;

   assign run = hw_en && !sw_off;
   assign ppl = PPL_W'(BASE_PPL) + PPL_W'(act.hsw);

   expo_seq_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .staged  (staged),
      .sw_off  (sw_off),
      .mode_wr (mode_wr)
   );

   // working copy is taken only at a frame boundary
   always_ff @(posedge clk) begin
      if (!rst_n)                 act <= '0;
      else if (state == ST_START) act <= staged;
   end

   expo_seq_intcnt #(.PPL_W(PPL_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (state == ST_START),
      .en       (state == ST_EXPOSE),
      .pix_unit (act.pix_unit),
      .target   (act.expo),
      .ppl      (ppl),
      .hit      (exp_hit)
   );

   expo_seq_fsm #(.PPL_W(PPL_W), .ACT_PIX(ACT_PIX), .ROWS(ROWS)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .mode_wr    (mode_wr),
      .one_shot   (act.one_shot),
      .exp_hit    (exp_hit),
      .ppl        (ppl),
      .state      (state),
      .line_valid (line_valid)
   );

   assign frame_start = (state == ST_START);
   assign int_done    = (state == ST_EXPOSE) && exp_hit;
   assign halted      = (state == ST_HALT);

endmodule

// File: rtl/expo_seq_chk.sv
module expo_seq_chk
   import expo_seq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              hw_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              frame_start,
   input logic              line_valid,
   input logic              int_done,
   input logic              halted
);

   logic mode_write;
   assign mode_write = wr_en && (wr_addr == A_MODE);

   // R11
   hw_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_en |=> !frame_start && !line_valid && !int_done && !halted);

   // R14
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   // R14
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_done |=> !int_done);

   // R8
   lv_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> !frame_start && !int_done && !halted);

   // R8
   start_then_no_lv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !line_valid);

   // R9
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted && hw_en && !mode_write |=> halted);

   // R10
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted && hw_en && mode_write |=> !halted);

endmodule

bind expo_seq expo_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hw_en       (hw_en),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .frame_start (frame_start),
   .line_valid  (line_valid),
   .int_done    (int_done),
   .halted      (halted)
);

// File: tb/expo_seq_tb.sv
`timescale 1ns/1ps
module expo_seq_tb;

   localparam int BASE_PPL = 414;
   localparam int ACT_PIX  = 400;
   localparam int ROWS     = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       frame_start, line_valid, int_done, halted;

   always #4 clk = ~clk;

   expo_seq #(.BASE_PPL(BASE_PPL), .ACT_PIX(ACT_PIX), .ROWS(ROWS)) u_dut (
      .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .frame_start(frame_start),
      .line_valid(line_valid), .int_done(int_done), .halted(halted));

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int fs_cnt = 0, done_cnt = 0, last_fs = 0;
   int fs_period = 0, done_sp = 0;
   int lv_acc = 0, lv_last = 0, lv_total = 0;
   int pulse_err = 0;
   logic prev_fs = 1'b0, prev_done = 1'b0;

   // monitor: sampled away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (frame_start) begin
            fs_cnt++;
            fs_period = cyc - last_fs;
            last_fs = cyc;
            lv_last = lv_acc;
            lv_acc = 0;
         end
         if (int_done) begin
            done_cnt++;
            done_sp = cyc - last_fs;
         end
         if (line_valid) begin
            lv_acc++;
            lv_total++;
         end
         if ((frame_start && prev_fs) || (int_done && prev_done)) pulse_err++;
         prev_fs = frame_start;
         prev_done = int_done;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(input logic [7:0] mode, input logic [7:0] hs, input int n);
      wr(3'd0, mode);
      wr(3'd1, hs);
      wr(3'd2, n[23:16]);
      wr(3'd3, n[15:8]);
      wr(3'd4, n[7:0]);
   endtask

   task automatic wait_fs(input int target);
      for (int i = 0; i < 40000 && fs_cnt < target; i++) @(posedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // restart via enable, run two frame starts, report spacing, period, lv count
   task automatic run_frame(output int sp, output int per, output int lvn);
      int fs0;
      @(negedge clk); hw_en = 1'b0;
      @(negedge clk); fs0 = fs_cnt; hw_en = 1'b1;
      wait_fs(fs0 + 2);
      sp = done_sp; per = fs_period; lvn = lv_last;
   endtask

   function automatic int exp_sp(input bit pix, input int n, input int hs);
      if (pix) return n + 1;
      return ((n >> 8) & 16'hffff) * (BASE_PPL + hs) + 1;
   endfunction

   function automatic int exp_per(input int sp, input int hs);
      return sp + 1 + ROWS * (BASE_PPL + hs);
   endfunction

   initial begin
      int sp, per, lvn, n, hs, f0, d0;
      void'($urandom(32'h00c0ffee));

      // R1: reset state
      idle(4);
      check("R1 reset fs", int'(frame_start), 0);
      check("R1 reset lv/done/halt", int'(line_valid | int_done | halted), 0);
      rst_n = 1'b1;
      idle(2);
      check("R1 first frame_start", fs_cnt, 1);
      idle(1);
      // R6: default target zero
      check("R6 zero target spacing", done_sp, 1);

      // R5: default line unit, mid byte = 1 -> one line
      wr(3'd3, 8'd1);
      run_frame(sp, per, lvn);
      check("R5 default line unit", sp, BASE_PPL + 1);
      check("R7 period default", per, exp_per(BASE_PPL + 1, 0));

      // R2/R4/R7/R8: pixel unit, random
      for (int k = 0; k < 4; k++) begin
         n = $urandom_range(1, 3000);
         hs = $urandom_range(0, 255);
         cfg(8'h01, 8'(hs), n);
         run_frame(sp, per, lvn);
         check("R2 pixel spacing", sp, exp_sp(1, n, hs));
         check("R4/R7 period with sync width", per, exp_per(exp_sp(1, n, hs), hs));
         check("R8 line_valid count", lvn, ROWS * ACT_PIX);
      end

      // R6: pixel unit zero
      cfg(8'h01, 8'd7, 0);
      run_frame(sp, per, lvn);
      check("R6 pixel zero spacing", sp, 1);

      // R3/R4: line unit, random low byte ignored
      for (int k = 0; k < 4; k++) begin
         hs = $urandom_range(0, 255);
         n = ($urandom_range(0, 3) << 8) | $urandom_range(1, 255);
         cfg(8'h00, 8'(hs), n);
         run_frame(sp, per, lvn);
         check("R3 line spacing", sp, exp_sp(0, n, hs));
         check("R4 line period", per, exp_per(exp_sp(0, n, hs), hs));
      end

      // R13: mid-frame write
      cfg(8'h01, 8'd0, 300);
      @(negedge clk); hw_en = 1'b0;
      @(negedge clk); f0 = fs_cnt; hw_en = 1'b1;
      wait_fs(f0 + 1);
      idle(20);
      wr(3'd3, 8'd0);
      wr(3'd4, 8'd50);
      wait_fs(f0 + 2);
      check("R13 current frame unchanged", done_sp, 301);
      d0 = done_cnt;
      for (int i = 0; i < 5000 && done_cnt == d0; i++) @(posedge clk);
      check("R13 next frame uses new value", done_sp, 51);

      // R9: single shot
      cfg(8'h03, 8'd0, 10);
      @(negedge clk); hw_en = 1'b0;
      @(negedge clk); f0 = fs_cnt; hw_en = 1'b1;
      idle(3000);
      check("R9 exactly one frame_start", fs_cnt - f0, 1);
      check("R9 halted set", int'(halted), 1);
      // R10: re-arm by mode write
      wr(3'd0, 8'h03);
      idle(3000);
      check("R10 rearm by write", fs_cnt - f0, 2);
      check("R10 halted again", int'(halted), 1);
      @(negedge clk); hw_en = 1'b0;
      @(negedge clk); hw_en = 1'b1;
      idle(3000);
      check("R10 rearm by enable", fs_cnt - f0, 3);

      // R11: hardware enable low
      wr(3'd0, 8'h01);
      idle(5);
      @(negedge clk); hw_en = 1'b0;
      idle(2);
      f0 = fs_cnt; d0 = lv_total;
      check("R11 outputs low", int'(frame_start | line_valid | int_done | halted), 0);
      idle(3000);
      check("R11 no frame while off", fs_cnt - f0, 0);
      check("R11 no line_valid while off", lv_total - d0, 0);

      // R12: software off
      wr(3'd0, 8'h05);
      @(negedge clk); hw_en = 1'b1;
      f0 = fs_cnt;
      idle(3000);
      check("R12 sw off idles", fs_cnt - f0, 0);
      wr(3'd0, 8'h01);
      idle(2);
      check("R12 sw on restarts", fs_cnt - f0, 1);

      // R14
      check("R14 single-cycle pulses", pulse_err, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1500000;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule